// File: doc/BRIEF.md
# Mailbox Command Word Writer

This block hands a command to a coprocessor through a window of 16-bit mailbox registers. The receiver acts on a command as soon as its command word changes. So the writer lays down every parameter word first, then the length word, and only then the command word. The command word is therefore the commit trigger, and the receiver never sees a half-built command.

The host can give the block a buffer of raw words together with a word count. It can also give the fields of a satellite-control request: an opcode, a byte message, its length and a burst selector. In the second case the block packs these fields into a fixed 18-word buffer itself. On start the block captures the buffer and issues single-cycle addressed writes on a simple write bus. After every write it waits a settle time, set in clock cycles by a parameter, before the next write. A one-cycle done pulse marks the end of the settle time that follows the final write.

Top module: `mbox_cmd_writer`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `bus_wr_o` are all low, and no write happens until a start is given.
- R2: Buffer word i is always written at address `BASE_ADDR + 2*i`.
- R3: Words 2 through count-1 are written first, one write each, in ascending index order. If the count is 2 or less, none of these writes happens.
- R4: The length word (index 1) is written next, at `BASE_ADDR + 2`. Its data is buffer word 1, or 0x0000 when the count is zero.
- R5: The command word (index 0) is always the last write of a run, at `BASE_ADDR`.
- R6: Each write is a one-cycle strobe. Consecutive writes of a run start exactly `DELAY_CYC + 1` cycles apart.
- R7: The first write strobe occurs in the cycle after the start is accepted. `busy_o` is high from that cycle until the run ends. `done_o` pulses for one cycle, `DELAY_CYC + 1` cycles after the final write strobe, and `busy_o` is low in that cycle.
- R8: A start that arrives while `busy_o` is high is ignored. The run in progress completes unchanged, and exactly one done pulse is produced.
- R9: For a packed request (`kind_i` = 1), the message length is clamped to `MAX_MSG` (10) bytes. Word 1 holds the clamped length + 2, word 2 holds the clamped length, word 0 holds the opcode, and the run always writes all 18 words.
- R10: In a packed request, word 3 encodes `ctl_burst_i` as follows: 2'b10 gives 0x0001, 2'b01 gives 0x0000, and 2'b00 or 2'b11 gives 0xFFFF.
- R11: In a packed request, word 4+k holds message byte k (byte k at `ctl_msg_i[8k+7:8k]`), zero-extended, for k below the clamped length. All other words from index 4 up to 17 are 0x0000.
- R12: A raw count (`kind_i` = 0) above `NWORDS` is treated as `NWORDS`. Raw word i is taken from `raw_words_i[16i+15:16i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a run; honoured only when idle |
| kind_i | input | 1 | 0 = raw buffer, 1 = pack a control request |
| raw_words_i | input | NWORDS*16 | Raw word buffer, word i in bits [16i+15:16i] |
| raw_count_i | input | CNT_IN_W | Raw word count |
| ctl_opcode_i | input | 16 | Command word for a packed request |
| ctl_len_i | input | 8 | Message length in bytes (clamped to MAX_MSG) |
| ctl_burst_i | input | 2 | Burst selector: 00 none, 01 A, 10 B, 11 none |
| ctl_msg_i | input | MAX_MSG*8 | Message bytes, byte k in bits [8k+7:8k] |
| bus_wr_o | output | 1 | Write strobe, one cycle per word |
| bus_addr_o | output | AW | Byte address of the word being written |
| bus_data_o | output | 16 | Data of the word being written |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench covers counts of 0, 1, 2 and the full buffer, because the length word is special in each of those cases. A design that skipped the zero substitution would leak stale word 1 data. A design that looped the parameter phase once too often would write index 2 on a short buffer. The bench also checks a raw count above the buffer depth and a packed message longer than the clamp. A wrong clamp would write past the window or put the wrong length into words 1 and 2. Finally, the bench issues a second start in the middle of a run. A design that re-armed on that start would change the write sequence or produce a second done pulse, and the bench would see either.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_WRITE  = 2'd1,
      ST_SETTLE = 2'd2
   } wr_state_e;

   typedef enum logic [1:0] {
      PH_PARAM = 2'd0,
      PH_LEN   = 2'd1,
      PH_CMD   = 2'd2
   } wr_phase_e;

   localparam logic [1:0] BURST_NONE  = 2'b00;
   localparam logic [1:0] BURST_A     = 2'b01;
   localparam logic [1:0] BURST_B     = 2'b10;

   localparam logic [WORD_W-1:0] BURST_WORD_A    = 16'h0000;
   localparam logic [WORD_W-1:0] BURST_WORD_B    = 16'h0001;
   localparam logic [WORD_W-1:0] BURST_WORD_NONE = 16'hFFFF;
endpackage

// File: rtl/mbox_req_packer.sv
module mbox_req_packer
   import mbox_pkg::*;
#(
   parameter int NWORDS  = 18,
   parameter int MAX_MSG = 10,
   localparam int CNT_W  = $clog2(NWORDS + 1)
) (
   input  logic [WORD_W-1:0]         opcode_i,
   input  logic [BYTE_W-1:0]         len_i,
   input  logic [1:0]                burst_i,
   input  logic [MAX_MSG*BYTE_W-1:0] msg_i,
   output logic [NWORDS*WORD_W-1:0]  words_o,
   output logic [CNT_W-1:0]          count_o
);
   localparam int HDR_WORDS = 4;

   if (NWORDS < HDR_WORDS + MAX_MSG) begin : g_bad_depth
      $error("mbox_req_packer: NWORDS too small for header plus message");
   end
   if (MAX_MSG < 1 || MAX_MSG > 253) begin : g_bad_msg
      $error("mbox_req_packer: MAX_MSG out of range");
   end

   logic [BYTE_W-1:0] len_eff;
   logic [WORD_W-1:0] burst_word;

   always_comb begin
      if (int'(len_i) > MAX_MSG) len_eff = BYTE_W'(MAX_MSG);
      else                       len_eff = len_i;
   end

   always_comb begin
      unique case (burst_i)
         BURST_A: burst_word = BURST_WORD_A;
         BURST_B: burst_word = BURST_WORD_B;
         default: burst_word = BURST_WORD_NONE;
      endcase
   end

   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      if (k == 0) begin : g_op
         assign words_o[k*WORD_W +: WORD_W] = opcode_i;
      end else if (k == 1) begin : g_total
         assign words_o[k*WORD_W +: WORD_W] = WORD_W'(len_eff) + WORD_W'(2);
      end else if (k == 2) begin : g_len
         assign words_o[k*WORD_W +: WORD_W] = WORD_W'(len_eff);
      end else if (k == 3) begin : g_burst
         assign words_o[k*WORD_W +: WORD_W] = burst_word;
      end else if (k < HDR_WORDS + MAX_MSG) begin : g_msg
         assign words_o[k*WORD_W +: WORD_W] =
            (int'(len_eff) > (k - HDR_WORDS)) ?
            {{(WORD_W-BYTE_W){1'b0}}, msg_i[(k-HDR_WORDS)*BYTE_W +: BYTE_W]} : '0;
      end else begin : g_pad
         assign words_o[k*WORD_W +: WORD_W] = '0;
      end
   end

   assign count_o = CNT_W'(NWORDS);
endmodule

// File: rtl/mbox_order_seq.sv
module mbox_order_seq
   import mbox_pkg::*;
#(
   parameter int NWORDS = 18,
   localparam int CNT_W = $clog2(NWORDS + 1),
   localparam int IDX_W = $clog2(NWORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic [CNT_W-1:0] init_count_i,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             len_phase_o,
   output logic             last_o
);
   wr_phase_e        phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] idx_next;

   assign idx_next = CNT_W'(idx_q) + CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         idx_q   <= '0;
      end else if (init_i) begin
         if (init_count_i > CNT_W'(2)) begin
            phase_q <= PH_PARAM;
            idx_q   <= IDX_W'(2);
         end else begin
            phase_q <= PH_LEN;
            idx_q   <= IDX_W'(1);
         end
      end else if (adv_i) begin
         unique case (phase_q)
            PH_PARAM: begin
               if (idx_next < count_i) begin
                  idx_q <= IDX_W'(idx_next);
               end else begin
                  phase_q <= PH_LEN;
                  idx_q   <= IDX_W'(1);
               end
            end
            PH_LEN: begin
               phase_q <= PH_CMD;
               idx_q   <= '0;
            end
            default: begin
               phase_q <= PH_CMD;
               idx_q   <= '0;
            end
         endcase
      end
   end

   assign idx_o       = idx_q;
   assign len_phase_o = (phase_q == PH_LEN);
   assign last_o      = (phase_q == PH_CMD);
endmodule

// File: rtl/mbox_settle_timer.sv
module mbox_settle_timer #(
   parameter int DELAY_CYC = 5000,
   localparam int TW       = $clog2(DELAY_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expire_o
);
   if (DELAY_CYC < 1) begin : g_bad_delay
      $error("mbox_settle_timer: DELAY_CYC must be at least 1");
   end

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= TW'(DELAY_CYC);
      else if (cnt_q != '0)    cnt_q <= cnt_q - TW'(1);
   end

   assign expire_o = (cnt_q == TW'(1));
endmodule

// File: rtl/mbox_cmd_writer.sv
module mbox_cmd_writer
   import mbox_pkg::*;
#(
   parameter int NWORDS    = 18,
   parameter int MAX_MSG   = 10,
   parameter int AW        = 16,
   parameter int BASE_ADDR = 'h0200,
   parameter int DELAY_CYC = 5000,
   parameter int CNT_IN_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       kind_i,
   input  logic [NWORDS*16-1:0]       raw_words_i,
   input  logic [CNT_IN_W-1:0]        raw_count_i,
   input  logic [15:0]                ctl_opcode_i,
   input  logic [7:0]                 ctl_len_i,
   input  logic [1:0]                 ctl_burst_i,
   input  logic [MAX_MSG*8-1:0]       ctl_msg_i,
   output logic                       bus_wr_o,
   output logic [AW-1:0]              bus_addr_o,
   output logic [15:0]                bus_data_o,
   output logic                       busy_o,
   output logic                       done_o
);
   localparam int CNT_W = $clog2(NWORDS + 1);
   localparam int IDX_W = $clog2(NWORDS);

   if (NWORDS < 3) begin : g_bad_nwords
      $error("mbox_cmd_writer: NWORDS must be at least 3");
   end
   if (AW < IDX_W + 2) begin : g_bad_aw
      $error("mbox_cmd_writer: AW too narrow for the mailbox window");
   end
   if (BASE_ADDR % 2 != 0) begin : g_bad_base
      $error("mbox_cmd_writer: BASE_ADDR must be even");
   end

   wr_state_e                 state_q;
   logic [WORD_W-1:0]         buf_q [NWORDS];
   logic [CNT_W-1:0]          cnt_q;
   logic                      done_q;

   logic [NWORDS*WORD_W-1:0]  pack_words;
   logic [CNT_W-1:0]          pack_count;
   logic [CNT_W-1:0]          raw_count_eff;
   logic [NWORDS*WORD_W-1:0]  sel_words;
   logic [CNT_W-1:0]          sel_count;

   logic                      accept;
   logic                      settle_done;
   logic [IDX_W-1:0]          idx;
   logic                      len_phase;
   logic                      last_word;

   mbox_req_packer #(
      .NWORDS  (NWORDS),
      .MAX_MSG (MAX_MSG)
   ) u_pack (
      .opcode_i (ctl_opcode_i),
      .len_i    (ctl_len_i),
      .burst_i  (ctl_burst_i),
      .msg_i    (ctl_msg_i),
      .words_o  (pack_words),
      .count_o  (pack_count)
   );

   always_comb begin
      if (int'(raw_count_i) > NWORDS) raw_count_eff = CNT_W'(NWORDS);
      else                            raw_count_eff = CNT_W'(raw_count_i);
   end

   assign sel_words = kind_i ? pack_words : raw_words_i;
   assign sel_count = kind_i ? pack_count : raw_count_eff;
   assign accept    = start_i && (state_q == ST_IDLE);

   mbox_order_seq #(
      .NWORDS (NWORDS)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .init_i       (accept),
      .init_count_i (sel_count),
      .adv_i        ((state_q == ST_SETTLE) && settle_done && !last_word),
      .count_i      (cnt_q),
      .idx_o        (idx),
      .len_phase_o  (len_phase),
      .last_o       (last_word)
   );

   mbox_settle_timer #(
      .DELAY_CYC (DELAY_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (state_q == ST_WRITE),
      .expire_o (settle_done)
   );

   for (genvar w = 0; w < NWORDS; w++) begin : g_buf
      always_ff @(posedge clk) begin
         if (!rst_n)      buf_q[w] <= '0;
         else if (accept) buf_q[w] <= sel_words[w*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_WRITE;
                  cnt_q   <= sel_count;
               end
            end
            ST_WRITE: state_q <= ST_SETTLE;
            ST_SETTLE: begin
               if (settle_done) begin
                  if (last_word) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_WRITE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_wr_o   = (state_q == ST_WRITE);
   assign bus_addr_o = AW'(BASE_ADDR) + AW'({idx, 1'b0});
   assign bus_data_o = (len_phase && cnt_q == '0) ? '0 : buf_q[idx];
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
endmodule

// File: rtl/mbox_cmd_writer_chk.sv
module mbox_cmd_writer_chk #(
   parameter int NWORDS    = 18,
   parameter int AW        = 16,
   parameter int BASE_ADDR = 'h0200,
   parameter int DELAY_CYC = 5000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr_o,
   input logic [AW-1:0] bus_addr_o,
   input logic          busy_o,
   input logic          done_o
);
   localparam int GW = $clog2(DELAY_CYC + 1);
   localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);
   localparam logic [AW-1:0] TOP  = AW'(BASE_ADDR + 2*NWORDS);

   logic [GW-1:0] gap_q;
   logic          seen_q;
   logic [AW-1:0] last_addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q       <= '0;
         seen_q      <= 1'b0;
         last_addr_q <= '0;
      end else if (bus_wr_o) begin
         gap_q       <= '0;
         seen_q      <= 1'b1;
         last_addr_q <= bus_addr_o;
      end else if (gap_q != GW'(DELAY_CYC)) begin
         gap_q <= gap_q + GW'(1);
      end
   end

   // R1: no write strobe while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bus_wr_o);

   // R2: writes stay inside the word-aligned window
   a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o |-> (bus_addr_o >= BASE && bus_addr_o < TOP && !bus_addr_o[0]));

   // R4: the command word is preceded by the length word
   a_r4_len_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o && bus_addr_o == BASE) |-> (last_addr_q == BASE + AW'(2)));

   // R5: a run ends on the command word
   a_r5_cmd_last: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (seen_q && last_addr_q == BASE));

   // R6: one-cycle strobes separated by the settle time
   a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o |=> !bus_wr_o);

   a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o && seen_q) |-> (gap_q == GW'(DELAY_CYC)));

   // R7: done is a single pulse while idle, and busy only ends with done
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
endmodule

bind mbox_cmd_writer mbox_cmd_writer_chk #(
   .NWORDS    (NWORDS),
   .AW        (AW),
   .BASE_ADDR (BASE_ADDR),
   .DELAY_CYC (DELAY_CYC)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr_o   (bus_wr_o),
   .bus_addr_o (bus_addr_o),
   .busy_o     (busy_o),
   .done_o     (done_o)
);

// File: tb/mbox_cmd_writer_test.sv
`timescale 1ns/1ps
module mbox_cmd_writer_test;
   localparam int NW    = 18;
   localparam int MM    = 10;
   localparam int AW    = 16;
   localparam int BASE  = 'h0300;
   localparam int DLY   = 3;
   localparam int CIW   = 8;
   localparam int MAXC  = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              kind_i = 1'b0;
   logic [NW*16-1:0]  raw_words_i = '0;
   logic [CIW-1:0]    raw_count_i = '0;
   logic [15:0]       ctl_opcode_i = '0;
   logic [7:0]        ctl_len_i = '0;
   logic [1:0]        ctl_burst_i = '0;
   logic [MM*8-1:0]   ctl_msg_i = '0;
   logic              bus_wr_o;
   logic [AW-1:0]     bus_addr_o;
   logic [15:0]       bus_data_o;
   logic              busy_o;
   logic              done_o;

   mbox_cmd_writer #(
      .NWORDS(NW), .MAX_MSG(MM), .AW(AW), .BASE_ADDR(BASE),
      .DELAY_CYC(DLY), .CNT_IN_W(CIW)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
      .raw_words_i(raw_words_i), .raw_count_i(raw_count_i),
      .ctl_opcode_i(ctl_opcode_i), .ctl_len_i(ctl_len_i),
      .ctl_burst_i(ctl_burst_i), .ctl_msg_i(ctl_msg_i),
      .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o), .bus_data_o(bus_data_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   always #4 clk = ~clk;

   int tests_run = 0;
   int tests_failed = 0;
   int cyc = 0;

   int        n_cap = 0;
   logic [15:0] cap_addr [MAXC];
   logic [15:0] cap_data [MAXC];
   int        cap_cyc  [MAXC];
   int        done_cnt = 0;
   int        done_cyc = 0;

   logic [15:0] exp_w [NW];
   int          exp_cnt;
   logic [15:0] exp_addr [MAXC];
   logic [15:0] exp_data [MAXC];
   int          n_exp;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && bus_wr_o && n_cap < MAXC) begin
         cap_addr[n_cap] = bus_addr_o;
         cap_data[n_cap] = bus_data_o;
         cap_cyc[n_cap]  = cyc;
         n_cap = n_cap + 1;
      end
      if (rst_n && done_o) begin
         done_cnt = done_cnt + 1;
         done_cyc = cyc;
      end
   end

   initial begin
      #1600000;
      tests_failed = tests_failed + 1;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests_run = tests_run + 1;
      if (!ok) begin
         tests_failed = tests_failed + 1;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // expected write list built from the ordering rules R2..R5
   task automatic build_expected();
      n_exp = 0;
      for (int i = 2; i < exp_cnt; i++) begin
         exp_addr[n_exp] = 16'(BASE + 2*i);
         exp_data[n_exp] = exp_w[i];
         n_exp++;
      end
      exp_addr[n_exp] = 16'(BASE + 2);
      exp_data[n_exp] = (exp_cnt == 0) ? 16'h0000 : exp_w[1];
      n_exp++;
      exp_addr[n_exp] = 16'(BASE);
      exp_data[n_exp] = exp_w[0];
      n_exp++;
   endtask

   task automatic launch(output int start_cyc);
      n_cap = 0;
      done_cnt = 0;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      start_cyc = cyc;
      chk(busy_o == 1'b1, "R7", "busy after start", int'(busy_o), 1);
   endtask

   task automatic wait_done();
      int guard = 0;
      while (done_cnt == 0 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk(done_cnt != 0, "R7", "done seen", done_cnt, 1);
      repeat (2) @(negedge clk);
   endtask

   task automatic compare_run(input int start_cyc, input string req);
      build_expected();
      chk(n_cap == n_exp, req, "write count", n_cap, n_exp);
      for (int j = 0; j < n_exp && j < n_cap; j++) begin
         chk(cap_addr[j] == exp_addr[j], req, $sformatf("R2 addr of write %0d", j),
             cap_addr[j], exp_addr[j]);
         chk(cap_data[j] == exp_data[j], req, $sformatf("data of write %0d", j),
             cap_data[j], exp_data[j]);
         if (j > 0)
            chk(cap_cyc[j] - cap_cyc[j-1] == DLY + 1, "R6", "write spacing",
                cap_cyc[j] - cap_cyc[j-1], DLY + 1);
      end
      if (n_cap > 0) begin
         chk(cap_cyc[0] == start_cyc, "R7", "first write cycle", cap_cyc[0], start_cyc);
         chk(cap_addr[n_cap-1] == 16'(BASE), "R5", "last write at base",
             cap_addr[n_cap-1], BASE);
         chk(done_cyc - cap_cyc[n_cap-1] == DLY + 1, "R7", "done delay",
             done_cyc - cap_cyc[n_cap-1], DLY + 1);
      end
      chk(done_cnt == 1, "R7", "single done pulse", done_cnt, 1);
      chk(busy_o == 1'b0, "R7", "idle after done", int'(busy_o), 0);
   endtask

   task automatic fill_raw(input int seed);
      for (int i = 0; i < NW; i++)
         raw_words_i[i*16 +: 16] = 16'(16'hA000 + seed * 16'h0100 + i * 3 + 1);
   endtask

   task automatic set_exp_raw(input int cnt);
      for (int i = 0; i < NW; i++) exp_w[i] = raw_words_i[i*16 +: 16];
      exp_cnt = (cnt > NW) ? NW : cnt;
   endtask

   task automatic run_raw(input int seed, input int cnt, input string req);
      int sc;
      kind_i = 1'b0;
      fill_raw(seed);
      raw_count_i = CIW'(cnt);
      set_exp_raw(cnt);
      launch(sc);
      wait_done();
      compare_run(sc, req);
   endtask

   task automatic run_ctl(input int len, input logic [1:0] burst, input string req);
      int sc;
      int le;
      kind_i = 1'b1;
      ctl_opcode_i = 16'h3C00 + 16'(len);
      ctl_len_i = 8'(len);
      ctl_burst_i = burst;
      for (int k = 0; k < MM; k++) ctl_msg_i[k*8 +: 8] = 8'(8'hE0 + k * 5);
      le = (len > MM) ? MM : len;
      for (int i = 0; i < NW; i++) exp_w[i] = 16'h0000;
      exp_w[0] = ctl_opcode_i;
      exp_w[1] = 16'(le + 2);
      exp_w[2] = 16'(le);
      exp_w[3] = (burst == 2'b10) ? 16'h0001 : (burst == 2'b01) ? 16'h0000 : 16'hFFFF;
      for (int k = 0; k < le; k++) exp_w[4 + k] = {8'h00, ctl_msg_i[k*8 +: 8]};
      exp_cnt = NW;
      launch(sc);
      wait_done();
      compare_run(sc, req);
   endtask

   task automatic t_reset();
      chk(busy_o == 1'b0, "R1", "busy at reset", int'(busy_o), 0);
      chk(done_o == 1'b0, "R1", "done at reset", int'(done_o), 0);
      chk(bus_wr_o == 1'b0, "R1", "wr at reset", int'(bus_wr_o), 0);
      repeat (10) @(negedge clk);
      chk(n_cap == 0, "R1", "no writes without start", n_cap, 0);
   endtask

   task automatic t_busy_start();
      int sc;
      kind_i = 1'b0;
      fill_raw(7);
      raw_count_i = CIW'(4);
      set_exp_raw(4);
      launch(sc);
      repeat (3) @(negedge clk);
      kind_i = 1'b1;
      raw_count_i = CIW'(9);
      fill_raw(9);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      repeat (100) @(negedge clk);
      compare_run(sc, "R8");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_raw(1, 5, "R3");
      run_raw(2, 0, "R4");
      run_raw(3, 1, "R4");
      run_raw(4, 2, "R3");
      run_raw(5, 18, "R3");
      run_raw(6, 25, "R12");
      run_ctl(3, 2'b10, "R9");
      run_ctl(14, 2'b00, "R9");
      run_ctl(0, 2'b01, "R10");
      run_ctl(10, 2'b11, "R11");
      t_busy_start();
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule